// File: doc/BRIEF.md
# Opcode-Driven 8-Bit ALU with Flags

This block is a clocked arithmetic logic unit for a small datapath. On each rising clock edge where the valid strobe is high, it decodes a 4-bit opcode and works on two 8-bit operands and a 3-bit shift amount. It then registers a 16-bit result and three status flags: carry, zero and negative. The result is 16 bits wide so that a full 8x8 product fits without truncation. All other operations return an 8-bit value with zeros in the upper byte.

One opcode stops the unit. Once the stop opcode is taken, every later command is ignored and the outputs keep their values until the active-low asynchronous reset is asserted. The reset also clears the result and the flags. Encodings 13 to 15 are reserved and have no effect.

Top module: `op_alu`

## Requirements
- R1: Asserting rst_ni low clears result_o, flags_o and the stopped state, so that all outputs read zero.
- R2: The opcode encodings are MOV=0 (result = A), ADD=1, SUB=2, MUL=3, AND=4, OR=5, LSR=6, LSL=7, ASR=8, ASL=9, COMP=10, NEG=11 and HALT=12. The result and flags update on the rising edge at which valid_i is high.
- R3: ADD returns the 8-bit sum of A and B, zero-extended, with carry set to the ninth bit of the sum.
- R4: SUB returns A-B modulo 256, with carry set when A<B (unsigned borrow). For example, A=10 and B=10 give result 0 with the zero flag set.
- R5: MUL returns the full 16-bit unsigned product. Its negative flag is result bit 15 and its carry is 0.
- R6: MOV, AND, OR, COMP (bitwise NOT of A) and NEG (two's complement of A) return 8-bit values with carry 0.
- R7: LSR and LSL shift A by shamt_i and fill with zeros. ASR shifts right and replicates A bit 7. ASL shifts left and fills with zeros. All shifts give 8-bit results.
- R8: For shifts, carry is the last bit shifted out of A. It is 0 when shamt_i is 0.
- R9: The flags are packed as flags_o[0]=carry, flags_o[1]=zero and flags_o[2]=negative. Zero is set exactly when all 16 result bits are 0. Negative is result bit 7 for every operation other than MUL.
- R10: When valid_i is low, result_o and flags_o keep their values.
- R11: Opcodes 13, 14 and 15 leave result_o and flags_o unchanged.
- R12: Once HALT is accepted, the outputs keep their current values and every later opcode is ignored until reset. The HALT itself does not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command strobe |
| op_i | input | 4 | Opcode |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| shamt_i | input | 3 | Shift amount for shift opcodes |
| result_o | output | 16 | Registered result |
| flags_o | output | 3 | Registered flags {negative, zero, carry} |

## Verification
The bench looks at three pairs of behaviours that meet in a single update. In the first, a shift pushes the last set bit of A out, so the carry and zero flags are both set on the same edge. In the second, a valid opcode comes on the cycle right after the HALT, so the bench sees whether the stopped state already blocks the very next command. In the third, reset is asserted while the unit is stopped. A behavioural model built on integers predicts the result and flags for each edge, and the bench compares them with the outputs after every clock.

// File: rtl/op_alu_pkg.sv
package op_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_LSR  = 4'd6,
    OP_LSL  = 4'd7,
    OP_ASR  = 4'd8,
    OP_ASL  = 4'd9,
    OP_COMP = 4'd10,
    OP_NEG  = 4'd11,
    OP_HALT = 4'd12
  } op_e;

  // packed MSB first: neg=bit2, zero=bit1, carry=bit0
  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
  } flags_t;
endpackage

// File: rtl/op_alu_arith.sv
module op_alu_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [DATA_W:0]     sum_o,
  output logic [DATA_W-1:0]   diff_o,
  output logic                borrow_o,
  output logic [2*DATA_W-1:0] prod_o
);
  logic [DATA_W:0] diff_ext;

  assign sum_o    = {1'b0, a_i} + {1'b0, b_i};
  assign diff_ext = {1'b0, a_i} - {1'b0, b_i};
  assign diff_o   = diff_ext[DATA_W-1:0];
  assign borrow_o = diff_ext[DATA_W];
  assign prod_o   = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
endmodule

// File: rtl/op_alu_shift.sv
module op_alu_shift #(
  parameter int DATA_W = 8,
  parameter bit LEFT   = 1'b0,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  // one guard bit catches the last bit shifted out
  logic [DATA_W:0] ext;

  generate
    if (LEFT) begin : g_left
      assign ext    = {1'b0, a_i} << sh_i;
      assign res_o  = ext[DATA_W-1:0];
      assign cout_o = ext[DATA_W];
    end else begin : g_right
      logic signed [DATA_W:0] sx;
      assign sx     = $signed({a_i, 1'b0}) >>> sh_i;
      assign ext    = arith_i ? $unsigned(sx) : ({a_i, 1'b0} >> sh_i);
      assign res_o  = ext[DATA_W:1];
      assign cout_o = ext[0];
    end
  endgenerate
endmodule

// File: rtl/op_alu.sv
module op_alu
  import op_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [3:0]                  op_i,
  input  logic [DATA_W-1:0]           a_i,
  input  logic [DATA_W-1:0]           b_i,
  input  logic [$clog2(DATA_W)-1:0]   shamt_i,
  output logic [2*DATA_W-1:0]         result_o,
  output logic [2:0]                  flags_o
);
  localparam int RES_W = 2 * DATA_W;
  localparam int SH_W  = $clog2(DATA_W);
  localparam int PAD_W = RES_W - DATA_W;

  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] diff;
  logic              borrow;
  logic [RES_W-1:0]  prod;
  logic [DATA_W-1:0] shr_res, shl_res;
  logic              shr_c, shl_c;

  op_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i(a_i), .b_i(b_i), .sum_o(sum), .diff_o(diff),
    .borrow_o(borrow), .prod_o(prod)
  );

  op_alu_shift #(.DATA_W(DATA_W), .LEFT(1'b0)) u_shr (
    .a_i(a_i), .sh_i(shamt_i[SH_W-1:0]), .arith_i(op_i == OP_ASR),
    .res_o(shr_res), .cout_o(shr_c)
  );

  op_alu_shift #(.DATA_W(DATA_W), .LEFT(1'b1)) u_shl (
    .a_i(a_i), .sh_i(shamt_i[SH_W-1:0]), .arith_i(1'b0),
    .res_o(shl_res), .cout_o(shl_c)
  );

  logic [DATA_W-1:0] low8;
  logic [RES_W-1:0]  nxt_res;
  logic              nxt_c;
  logic              upd;
  flags_t            nxt_flg;
  logic              halt_q;
  logic [RES_W-1:0]  res_q;
  flags_t            flg_q;

  always_comb begin
    low8  = '0;
    nxt_c = 1'b0;
    upd   = 1'b1;
    unique case (op_e'(op_i))
      OP_MOV:          low8 = a_i;
      OP_ADD:  begin   low8 = sum[DATA_W-1:0]; nxt_c = sum[DATA_W]; end
      OP_SUB:  begin   low8 = diff; nxt_c = borrow; end
      OP_AND:          low8 = a_i & b_i;
      OP_OR:           low8 = a_i | b_i;
      OP_LSR, OP_ASR: begin low8 = shr_res; nxt_c = shr_c; end
      OP_LSL, OP_ASL: begin low8 = shl_res; nxt_c = shl_c; end
      OP_COMP:         low8 = ~a_i;
      OP_NEG:          low8 = -a_i;
      OP_MUL:          low8 = '0;
      default:         upd  = 1'b0;   // HALT and reserved codes
    endcase
    nxt_res      = (op_i == OP_MUL) ? prod : {{PAD_W{1'b0}}, low8};
    nxt_flg.carry = nxt_c;
    nxt_flg.zero  = (nxt_res == '0);
    nxt_flg.neg   = (op_i == OP_MUL) ? nxt_res[RES_W-1] : nxt_res[DATA_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      res_q  <= '0;
      flg_q  <= '0;
    end else if (valid_i && !halt_q) begin
      if (op_i == OP_HALT) begin
        halt_q <= 1'b1;
      end else if (upd) begin
        res_q <= nxt_res;
        flg_q <= nxt_flg;
      end
    end
  end

  assign result_o = res_q;
  assign flags_o  = flg_q;
endmodule

// File: rtl/op_alu_chk.sv
module op_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [3:0]          op_i,
  input logic [DATA_W-1:0]   a_i,
  input logic [DATA_W-1:0]   b_i,
  input logic [2*DATA_W-1:0] result_o,
  input logic [2:0]          flags_o,
  input logic                halt_q
);
  localparam int RES_W = 2 * DATA_W;

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(flags_o)));

  // R11
  reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 4'd13) |=> ($stable(result_o) && $stable(flags_o)));

  // R12
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> halt_q);

  // R12
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> ($stable(result_o) && $stable(flags_o)));

  // R9
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] |-> (result_o == '0));

  // R3
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !halt_q && op_i == 4'd1) |=>
      ({flags_o[0], result_o[DATA_W-1:0]} ==
       ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  // R6
  upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !halt_q && op_i <= 4'd11 && op_i != 4'd3) |=>
      (result_o[RES_W-1:DATA_W] == '0));
endmodule

bind op_alu op_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/op_alu_test.sv
`timescale 1ns/1ps
module op_alu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [7:0]  a_i = '0;
  logic [7:0]  b_i = '0;
  logic [2:0]  shamt_i = '0;
  logic [15:0] result_o;
  logic [2:0]  flags_o;

  int n_chk = 0;
  int n_err = 0;
  int m_res = 0;
  int m_flg = 0;
  bit m_halt = 1'b0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  op_alu uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(input string tag);
    n_chk++;
    if (result_o !== 16'(m_res) || flags_o !== 3'(m_flg)) begin
      n_err++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               tag, result_o, flags_o, 16'(m_res), 3'(m_flg));
    end
  endtask

  task automatic model(input int op, input int a, input int b, input int sh);
    int r, c, sa;
    c = 0;
    case (op)
      0: r = a;
      1: begin r = (a + b) & 255; c = ((a + b) >> 8) & 1; end
      2: begin r = (a - b) & 255; c = (a < b) ? 1 : 0; end
      3: r = a * b;
      4: r = a & b;
      5: r = a | b;
      6: begin r = a >> sh; c = (sh != 0) ? ((a >> (sh - 1)) & 1) : 0; end
      7, 9: begin r = (a << sh) & 255; c = (sh != 0) ? ((a >> (8 - sh)) & 1) : 0; end
      8: begin
        sa = (a >= 128) ? a - 256 : a;
        r = (sa >>> sh) & 255;
        c = (sh != 0) ? ((a >> (sh - 1)) & 1) : 0;
      end
      10: r = (~a) & 255;
      11: r = (-a) & 255;
      default: r = 0;
    endcase
    m_res = r;
    m_flg = c | ((r == 0) ? 2 : 0) |
            ((((op == 3) ? (r >> 15) : (r >> 7)) & 1) << 2);
  endtask

  task automatic step(input bit v, input int op, input int a, input int b,
                      input int sh, input string tag);
    @(negedge clk_i);
    valid_i = v; op_i = 4'(op); a_i = 8'(a); b_i = 8'(b); shamt_i = 3'(sh);
    if (v && !m_halt) begin
      if (op == 12) m_halt = 1'b1;
      else if (op <= 11) model(op, a, b, sh);
    end
    @(posedge clk_i);
    #1;
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0;
    m_res = 0; m_flg = 0; m_halt = 1'b0;
    @(posedge clk_i);
    #1;
    check("R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: result=%h flags=%b expected completion", result_o, flags_o);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(1, 0, 8'h5A, 0, 0, "R2 mov");
    step(1, 0, 8'h80, 0, 0, "R9 mov negative");
    step(1, 1, 200, 100, 0, "R3 add carry");
    step(1, 1, 10, 20, 0, "R3 add");
    step(1, 2, 10, 10, 0, "R4 sub zero");
    step(1, 2, 5, 9, 0, "R4 sub borrow");
    step(1, 3, 255, 255, 0, "R5 mul full");
    step(1, 3, 3, 4, 0, "R5 mul small");
    step(1, 3, 0, 77, 0, "R5 mul zero");
    step(1, 4, 8'hF0, 8'h3C, 0, "R6 and");
    step(1, 5, 8'hF0, 8'h0C, 0, "R6 or");
    step(1, 10, 8'h0F, 0, 0, "R6 comp");
    step(1, 11, 0, 0, 0, "R6 neg zero");
    step(1, 11, 1, 0, 0, "R6 neg");
    step(1, 6, 8'h81, 0, 1, "R7 lsr");
    step(1, 7, 8'h81, 0, 1, "R7 lsl");
    step(1, 8, 8'h80, 0, 3, "R7 asr");
    step(1, 9, 8'h41, 0, 0, "R8 asl zero shift");
    step(1, 6, 8'h01, 0, 1, "R8 lsr carry and zero");
    step(1, 7, 8'h80, 0, 1, "R8 lsl carry and zero");
    step(1, 8, 8'h7F, 0, 7, "R8 asr positive");
    step(0, 1, 9, 9, 0, "R10 idle");
    step(1, 13, 1, 1, 0, "R11 reserved 13");
    step(1, 14, 1, 1, 0, "R11 reserved 14");
    step(1, 15, 1, 1, 0, "R11 reserved 15");
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 14));
      if (op >= 12) op = op + 1;
      step(($urandom_range(0, 3) != 0), op, int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 7)), "R2 sweep");
    end
    step(1, 1, 1, 2, 0, "R3 before halt");
    step(1, 12, 0, 0, 0, "R12 halt keeps outputs");
    step(1, 1, 50, 60, 0, "R12 next op ignored");
    step(1, 3, 200, 200, 0, "R12 mul ignored");
    step(1, 11, 5, 0, 0, "R12 neg ignored");
    do_reset();
    step(1, 1, 7, 8, 0, "R1 halt cleared");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule